// File: doc/BRIEF.md
# Boost PFC Switching-Cycle Controller

This block produces the gate command for a boost power-factor stage from a fast system clock. It divides the clock into fixed switching periods. Each period opens with a forced-off interval during which an internal digital ramp is held at zero. When that interval ends, the ramp counts up by one per clock, and the gate is switched on once the ramp reaches the effective current command. The gate then stays on to the end of the period. The off time therefore grows with the command, and the gate is on for what is left of the period.

A peak-current input passes through a filter that needs the input held high for several clocks without a break. Once the filter trips, a limit latch turns the gate off at once and keeps it off for the rest of the period. The opening interval of every period clears both the on-latch and the limit latch, and it takes priority over every other input. A supply-fault input forces the gate low in the same cycle and restarts the period. A duty-reduction input is subtracted from the current command. The difference stops at zero.

The phase of a period is the number of rising clock edges since reset or fault was released, modulo `PERIOD_CYC`. Phase 0 is the interval before the first such edge. The effective command is `eff = max(cmd_i - trim_i, 0)`.

Top module: `pfc_pwm_core`

## Requirements
- R1: While `rst_n` is low, `gate_o` is 0.
- R2: In phases 0 to `MINOFF_CYC-1` of every period, `gate_o` is 0 and the ramp is held at zero.
- R3: The gate first goes high at phase `MINOFF_CYC + eff` and stays high through phase `PERIOD_CYC-1`, so each period has `PERIOD_CYC - MINOFF_CYC - eff` on-cycles.
- R4: With `eff = 0`, the on-time is the largest possible, `PERIOD_CYC - MINOFF_CYC` cycles (95 % with the default parameters).
- R5: With `eff >= PERIOD_CYC - MINOFF_CYC`, the gate stays low for the whole period (0 % duty).
- R6: `trim_i` reduces the command as `eff = cmd_i - trim_i`. When `trim_i > cmd_i`, `eff` is 0.
- R7: When the filtered current limit trips, the gate is low from the next phase through the end of the period, even if the raw input has dropped.
- R8: The limit trips only after `ilim_raw_i` has been 1 at `FILT_CYC` consecutive rising edges. It takes effect from the phase that follows the last of those edges. Shorter pulses, and pulses broken by a low cycle, leave the gate unaffected.
- R9: The opening interval of each period clears both the on-latch and the limit latch, and it overrides all other inputs. The next period therefore runs normally. If the raw limit stays high across the boundary, the limit is set again at phase `MINOFF_CYC`, before the gate can rise.
- R10: `fault_i` = 1 forces `gate_o` low in the same cycle and clears the counter, the ramp and both latches. After release, the period restarts at phase 0.
- R11: The period is exactly `PERIOD_CYC` clocks, so consecutive periods produce identical gate patterns for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Supply fault: gate low, period restart |
| ilim_raw_i | input | 1 | Unfiltered peak-current-limit comparator |
| cmd_i | input | CMD_W | Averaged-current command, compared with the ramp |
| trim_i | input | CMD_W | Duty reduction, subtracted from the command |
| gate_o | output | 1 | Active-high gate command |

## Verification
Each state element adds one edge of latency. The on-latch and the limit latch are set on the edge that ends the qualifying phase. An on-transition therefore appears at the phase that equals the crossing count, and a trip appears at the phase right after the `FILT_CYC`-th high edge. The fault path is combinational, so its effect is due in the same cycle. The bench keeps its own phase counter, reset by reset and by fault. It samples `gate_o` on falling edges and changes stimulus only just after a sample, so every observation falls at a known phase. Per-period on-counts and first-on phases are then compared with the formulas above.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

    // Set/reset latch pair of the switching cycle
    typedef struct packed {
        logic pwm_on;
        logic ilim;
    } pwm_latch_t;

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
    parameter int PERIOD_CYC = 1000,
    parameter int MINOFF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    output logic hold_now_o,
    output logic hold_next_o
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST  = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] MINOFF = CW'(MINOFF_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_now_o  = (st_q.cnt < MINOFF);
    assign hold_next_o = (st_d.cnt < MINOFF);

endmodule

// File: rtl/pwm_ramp_cmp.sv
module pwm_ramp_cmp #(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_now_i,
    input  logic             hold_next_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [CMD_W-1:0] trim_i,
    output logic [CMD_W-1:0] ramp_o,
    output logic             cross_next_o
);
    typedef struct packed {
        logic [CMD_W-1:0] ramp;
    } ramp_t;

    ramp_t            st_d, st_q;
    logic [CMD_W-1:0] eff;

    always_comb begin
        eff  = (cmd_i > trim_i) ? (cmd_i - trim_i) : '0;
        st_d = st_q;
        if (hold_next_i || hold_now_i) begin
            st_d.ramp = '0;
        end else if (st_q.ramp != {CMD_W{1'b1}}) begin
            st_d.ramp = st_q.ramp + 1'b1;
        end
        cross_next_o = (st_d.ramp >= eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ramp_o = st_q.ramp;

endmodule

// File: rtl/pwm_spike_filter.sv
module pwm_spike_filter #(
    parameter int FILT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic trip_next_o
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] FULL = FW'(FILT_CYC);

    typedef struct packed {
        logic [FW-1:0] run;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!raw_i) begin
            st_d.run = '0;
        end else if (st_q.run != FULL) begin
            st_d.run = st_q.run + 1'b1;
        end
        trip_next_o = (st_d.run == FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pfc_pwm_core.sv
module pfc_pwm_core
    import pfc_pwm_pkg::*;
#(
    parameter int PERIOD_CYC = 1000,
    parameter int MINOFF_CYC = 50,
    parameter int FILT_CYC   = 20,
    parameter int CMD_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_i,
    input  logic             ilim_raw_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [CMD_W-1:0] trim_i,
    output logic             gate_o
);
    logic             hold_now, hold_next;
    logic             cross_next, trip_next;
    logic [CMD_W-1:0] ramp_q;
    pwm_latch_t       lat_d, lat_q;

    pwm_period_timer #(
        .PERIOD_CYC(PERIOD_CYC),
        .MINOFF_CYC(MINOFF_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (fault_i),
        .hold_now_o (hold_now),
        .hold_next_o(hold_next)
    );

    pwm_ramp_cmp #(
        .CMD_W(CMD_W)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_now_i  (hold_now),
        .hold_next_i (hold_next),
        .cmd_i       (cmd_i),
        .trim_i      (trim_i),
        .ramp_o      (ramp_q),
        .cross_next_o(cross_next)
    );

    pwm_spike_filter #(
        .FILT_CYC(FILT_CYC)
    ) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (ilim_raw_i),
        .trip_next_o(trip_next)
    );

    // Opening interval wins over the set inputs of both latches
    always_comb begin
        lat_d = lat_q;
        if (hold_next) begin
            lat_d = '0;
        end else begin
            lat_d.pwm_on = lat_q.pwm_on | cross_next;
            lat_d.ilim   = lat_q.ilim | trip_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign gate_o = lat_q.pwm_on & ~lat_q.ilim & ~fault_i;

endmodule

// File: rtl/pfc_pwm_core_chk.sv
module pfc_pwm_core_chk #(
    parameter int CMD_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_i,
    input logic             ilim_raw_i,
    input logic             hold_now,
    input logic             pwm_q,
    input logic             lim_q,
    input logic [CMD_W-1:0] ramp_q,
    input logic             gate_o
);
    a_r2_gate_off_in_minoff: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |-> !gate_o);

    a_r2_ramp_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |-> (ramp_q == '0));

    a_r3_ramp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_now && $past(!hold_now)) |->
            (ramp_q == CMD_W'($past(ramp_q) + 1'b1) || ramp_q == {CMD_W{1'b1}}));

    a_r3_on_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwm_q) && !hold_now) |-> pwm_q);

    a_r7_limit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lim_q) && !hold_now) |-> lim_q);

    a_r8_trip_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lim_q) |-> $past(ilim_raw_i));

    a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (hold_now && !pwm_q && !lim_q));

endmodule

bind pfc_pwm_core pfc_pwm_core_chk #(.CMD_W(CMD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (fault_i),
    .ilim_raw_i(ilim_raw_i),
    .hold_now  (hold_now),
    .pwm_q     (lat_q.pwm_on),
    .lim_q     (lat_q.ilim),
    .ramp_q    (ramp_q),
    .gate_o    (gate_o)
);

// File: tb/pfc_pwm_core_test.sv
module pfc_pwm_core_test;
    localparam int P = 100;
    localparam int M = 5;
    localparam int F = 3;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fault = 1'b0;
    logic         raw = 1'b0;
    logic [W-1:0] cmd = '0;
    logic [W-1:0] trim = '0;
    logic         gate;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    bit done = 1'b0;

    pfc_pwm_core #(.PERIOD_CYC(P), .MINOFF_CYC(M), .FILT_CYC(F), .CMD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault), .ilim_raw_i(raw),
        .cmd_i(cmd), .trim_i(trim), .gate_o(gate)
    );

    always #10 clk = ~clk;

    // Phase model taken from the requirements
    always @(posedge clk) begin
        if (!rst_n || fault) ph <= 0;
        else ph <= (ph == P - 1) ? 0 : ph + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full period from phase 0; raw limit raised/dropped after sampling given phases
    task automatic measure(input int r1, input int f1, input int r2, input int f2,
                           output int on_n, output int first);
        on_n = 0;
        first = -1;
        while (ph != 0) @(negedge clk);
        for (int i = 0; i < P; i++) begin
            if (gate) begin
                on_n++;
                if (first < 0) first = i;
            end
            if (i == r1 || i == r2) raw = 1'b1;
            if (i == f1 || i == f2) raw = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic expect_period(input string req, input int on_e, input int first_e,
                                 input int r1, input int f1, input int r2, input int f2);
        int on_n, first;
        measure(r1, f1, r2, f2, on_n, first);
        check(on_n == on_e, {req, " on-cycles"}, on_n, on_e);
        check(first == first_e, {req, " first-on phase"}, first, first_e);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(gate == 1'b0, "R1 gate during reset", gate, 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_max_duty;
        cmd = 0; trim = 0;
        expect_period("R4 R2 max duty", P - M, M, -1, -1, -1, -1);
        expect_period("R11 repeat period", P - M, M, -1, -1, -1, -1);
    endtask

    task automatic t_crossing;
        cmd = 30; trim = 0;
        expect_period("R3 crossing eff=30", P - M - 30, M + 30, -1, -1, -1, -1);
        cmd = 1; trim = 0;
        expect_period("R3 crossing eff=1", P - M - 1, M + 1, -1, -1, -1, -1);
    endtask

    task automatic t_trim;
        cmd = 60; trim = 20;
        expect_period("R6 trim subtracts", P - M - 40, M + 40, -1, -1, -1, -1);
        cmd = 10; trim = 50;
        expect_period("R6 trim floors at zero", P - M, M, -1, -1, -1, -1);
    endtask

    task automatic t_min_duty;
        cmd = W'(P - M); trim = 0;
        expect_period("R5 zero duty at edge", 0, -1, -1, -1, -1, -1);
        cmd = 200; trim = 0;
        expect_period("R5 zero duty large", 0, -1, -1, -1, -1, -1);
        cmd = W'(P - M - 1); trim = 0;
        expect_period("R5 one cycle below", 1, P - 1, -1, -1, -1, -1);
    endtask

    task automatic t_limit;
        cmd = 10; trim = 0;
        expect_period("R7 R8 trip at phase 53", 38, M + 10, 50, 53, -1, -1);
        expect_period("R9 period after trip", P - M - 10, M + 10, -1, -1, -1, -1);
        expect_period("R8 short pulse ignored", P - M - 10, M + 10, 50, 52, -1, -1);
        expect_period("R8 broken pulse ignored", P - M - 10, M + 10, 40, 42, 43, 45);
    endtask

    task automatic t_sticky;
        cmd = 10; trim = 0;
        expect_period("R7 late trip", 93 - (M + 10), M + 10, 90, -1, -1, -1);
        expect_period("R9 limit reasserts after minoff", 0, -1, -1, 20, -1, -1);
        expect_period("R9 recovery", P - M - 10, M + 10, -1, -1, -1, -1);
    endtask

    task automatic t_fault;
        cmd = 10; trim = 0;
        while (ph != 60) @(negedge clk);
        check(gate == 1'b1, "R10 gate on before fault", gate, 1);
        fault = 1'b1;
        #1;
        check(gate == 1'b0, "R10 gate low same cycle", gate, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(gate == 1'b0, "R10 gate low while fault", gate, 0);
        end
        fault = 1'b0;
        expect_period("R10 restart after fault", P - M - 10, M + 10, -1, -1, -1, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_max_duty();
        t_crossing();
        t_trim();
        t_min_duty();
        t_limit();
        t_sticky();
        t_fault();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule